// File: doc/BRIEF.md
# NAND Flash Page and Block Controller

This block models a small array of NAND-style flash, organised as blocks that each hold a fixed number of pages, together with the controller that sequences operations on it. Commands arrive over a valid/ready interface. Each command names an operation, a block, a page and, for a program, a full page of write data. Three operations are supported: a page read, a page program and a whole-block erase.

While an operation runs, `busy` is high and no new command is taken. Each operation ends with a single-cycle `done` pulse. A program can only clear bits, so the stored page becomes the AND of its old contents and the new data. The only way to bring bits back to one is an erase, and an erase covers a whole block. Every latency is a parameter, and erase takes far longer than program, which takes far longer than read.

A read returns its page as a stream of words, one word per cycle. The block counts erases separately for each block and raises a sticky worn-out flag for any block whose count passes the endurance limit.

Top module: `nand_flash_ctrl`

## Requirements
- R1: After reset, every page reads as all ones, `busy`, `done`, `rd_valid` and `prog_conflict` are low, `cmd_ready` is high and all `worn` bits are low.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `busy` is high from the next cycle. While `busy` is high, `cmd_ready` is low and `cmd_valid` is ignored. A command may be taken in the same cycle that `done` is high.
- R3: `done` is high for exactly one cycle at the end of each command. `busy` is low in that cycle.
- R4: A program sets the addressed page to the bitwise AND of its previous contents and `cmd_wdata`.
- R5: `prog_conflict` rises together with `done` of a program whose `cmd_wdata` has a 1 in a position where the stored page holds 0. It stays high until the next command is taken, which clears it. A non-program command leaves it low.
- R6: An erase sets every page of the addressed block to all ones and leaves the other blocks unchanged.
- R7: `busy` stays high for READ_CYC+WORDS_PER_PAGE cycles on a read, PROG_CYC cycles on a program, ERASE_CYC cycles on an erase and 1 cycle on a no-op.
- R8: A read raises `rd_valid` for WORDS_PER_PAGE consecutive cycles at the end of its busy period. Page word i is bits [i*WORD_W +: WORD_W], and the words are sent in the order i = 0, 1, 2 and so on.
- R9: Each block has its own erase count. `worn[b]` goes high once block b has been erased more than WEAR_LIMIT times and never falls afterwards.
- R10: The `cmd_op` encoding is 2'b00 read, 2'b01 program, 2'b10 erase and 2'b11 no-op. A no-op changes no stored data and no wear count.
- R11: A program changes only the addressed page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_op | input | 2 | Operation code |
| cmd_block | input | $clog2(NUM_BLOCKS) | Block address |
| cmd_page | input | $clog2(PAGES_PER_BLOCK) | Page within the block |
| cmd_wdata | input | WORDS_PER_PAGE*WORD_W | Page data for a program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prog_conflict | output | 1 | The last program tried to raise a 0 to 1 |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | WORD_W | Read word |
| worn | output | NUM_BLOCKS | Per-block endurance exceeded flag |

## Verification
Two things can happen in the same cycle: the completion of one command and the acceptance of the next, because `cmd_ready` returns in the very cycle that `done` pulses. The bench provokes this by holding a read of the same page on `cmd_valid` while a program is still busy. It then judges that `cmd_ready` is high alongside `done`, that `busy` returns at once in the following cycle with no second `done`, and that the streamed words already show the newly programmed contents. The bench also offers an erase while a program is busy and later reads the page back to confirm the erase was dropped.

// File: rtl/nand_flash_ctrl.sv
module nand_flash_ctrl #(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 256,
  parameter int WORDS_PER_PAGE  = 2,
  parameter int WORD_W          = 8,
  parameter int READ_CYC        = 4,
  parameter int PROG_CYC        = 400,
  parameter int ERASE_CYC       = 40000,
  parameter int WEAR_LIMIT      = 10000
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       cmd_valid,
  output logic                                       cmd_ready,
  input  logic [1:0]                                 cmd_op,
  input  logic [$clog2(NUM_BLOCKS)-1:0]              cmd_block,
  input  logic [$clog2(PAGES_PER_BLOCK)-1:0]         cmd_page,
  input  logic [WORDS_PER_PAGE*WORD_W-1:0]           cmd_wdata,
  output logic                                       busy,
  output logic                                       done,
  output logic                                       prog_conflict,
  output logic                                       rd_valid,
  output logic [WORD_W-1:0]                          rd_data,
  output logic [NUM_BLOCKS-1:0]                      worn
);
  localparam int BLK_W     = $clog2(NUM_BLOCKS);
  localparam int PG_W      = $clog2(PAGES_PER_BLOCK);
  localparam int ADDR_W    = BLK_W + PG_W;
  localparam int NUM_PAGES = NUM_BLOCKS * PAGES_PER_BLOCK;
  localparam int PAGE_W    = WORDS_PER_PAGE * WORD_W;
  localparam int IDX_W     = $clog2(WORDS_PER_PAGE);
  localparam int MAX_LAT   = (ERASE_CYC > PROG_CYC) ?
                             ((ERASE_CYC > READ_CYC) ? ERASE_CYC : READ_CYC) :
                             ((PROG_CYC > READ_CYC) ? PROG_CYC : READ_CYC);
  localparam int CNT_W     = $clog2(MAX_LAT + 1);
  localparam int WEAR_W    = $clog2(WEAR_LIMIT + 2);
  localparam logic [WEAR_W-1:0] WEAR_TOP  = WEAR_W'(WEAR_LIMIT + 1);
  localparam logic [IDX_W-1:0]  LAST_WORD = IDX_W'(WORDS_PER_PAGE - 1);

  localparam logic [1:0] OP_READ  = 2'b00;
  localparam logic [1:0] OP_PROG  = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_STREAM} state_t;

  state_t              state;
  logic [CNT_W-1:0]    cnt;
  logic [1:0]          op_q;
  logic [BLK_W-1:0]    blk_q;
  logic [PG_W-1:0]     pg_q;
  logic [PAGE_W-1:0]   wdata_q;
  logic [IDX_W-1:0]    widx;
  logic [PAGE_W-1:0]   mem [NUM_PAGES];
  logic [NUM_PAGES-1:0] clean;
  logic [WEAR_W-1:0]   wear [NUM_BLOCKS];

  logic                accept, fin, do_prog, do_erase, last_beat;
  logic [ADDR_W-1:0]   page_idx;
  logic [PAGE_W-1:0]   cur_page;
  logic [CNT_W-1:0]    lat;

  assign busy      = (state != S_IDLE);
  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & cmd_ready;
  assign fin       = (state == S_WAIT) && (cnt == '0);
  assign do_prog   = fin && (op_q == OP_PROG);
  assign do_erase  = fin && (op_q == OP_ERASE);
  assign last_beat = (state == S_STREAM) && (widx == LAST_WORD);
  assign page_idx  = {blk_q, pg_q};
  assign cur_page  = clean[page_idx] ? {PAGE_W{1'b1}} : mem[page_idx];
  assign rd_valid  = (state == S_STREAM);
  assign rd_data   = WORD_W'(cur_page >> (WORD_W * int'(widx)));

  always_comb begin
    case (cmd_op)
      OP_READ:  lat = CNT_W'(READ_CYC - 1);
      OP_PROG:  lat = CNT_W'(PROG_CYC - 1);
      OP_ERASE: lat = CNT_W'(ERASE_CYC - 1);
      default:  lat = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      op_q    <= OP_READ;
      blk_q   <= '0;
      pg_q    <= '0;
      wdata_q <= '0;
      widx    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state   <= S_WAIT;
          cnt     <= lat;
          op_q    <= cmd_op;
          blk_q   <= cmd_block;
          pg_q    <= cmd_page;
          wdata_q <= cmd_wdata;
        end
        S_WAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (op_q == OP_READ) begin
            state <= S_STREAM;
            widx  <= '0;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_STREAM: begin
          widx <= widx + 1'b1;
          if (last_beat) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_prog) mem[page_idx] <= cur_page & wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clean <= '1;
    else if (do_prog) clean[page_idx] <= 1'b0;
    else if (do_erase)
      for (int p = 0; p < PAGES_PER_BLOCK; p++) clean[{blk_q, PG_W'(p)}] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_conflict <= 1'b0;
    else if (accept) prog_conflict <= 1'b0;
    else if (do_prog) prog_conflict <= |(wdata_q & ~cur_page);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BLOCKS; b++) wear[b] <= '0;
    end else if (do_erase && wear[blk_q] != WEAR_TOP) begin
      wear[blk_q] <= wear[blk_q] + 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_worn
    assign worn[b] = (wear[b] > WEAR_W'(WEAR_LIMIT));
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_stream_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy && !done));
  p_conflict_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_conflict) |-> done);
  p_worn_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((worn & $past(worn)) == $past(worn)));
endmodule

// File: tb/nand_flash_ctrl_bench.sv
module nand_flash_ctrl_bench;
  localparam int NB = 4, PPB = 8, WPP = 4, WW = 8;
  localparam int RC = 2, PC = 5, EC = 20, WL = 2;
  localparam int PW = WPP * WW;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [1:0] cmd_block = 0;
  logic [2:0] cmd_page = 0;
  logic [PW-1:0] cmd_wdata = 0;
  logic busy, done, prog_conflict, rd_valid;
  logic [WW-1:0] rd_data;
  logic [NB-1:0] worn;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [PW-1:0] model [NB*PPB];
  int wear_m [NB];
  string rd_tag = "R8";

  always #5 clk = ~clk;

  nand_flash_ctrl #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .WORDS_PER_PAGE(WPP),
    .WORD_W(WW), .READ_CYC(RC), .PROG_CYC(PC), .ERASE_CYC(EC), .WEAR_LIMIT(WL))
  u_nand_flash_ctrl (.clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_block,
    .cmd_page, .cmd_wdata, .busy, .done, .prog_conflict, .rd_valid, .rd_data, .worn);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [1:0] op);
    case (op)
      2'b00: return RC + WPP;
      2'b01: return PC;
      2'b10: return EC;
      default: return 1;
    endcase
  endfunction

  function automatic logic [NB-1:0] exp_worn();
    logic [NB-1:0] w;
    for (int b = 0; b < NB; b++) w[b] = (wear_m[b] > WL);
    return w;
  endfunction

  task automatic run(input logic [1:0] op, input int blk, input int pg,
                     input logic [PW-1:0] wd, input bit spam);
    int cycles, nw;
    logic [PW-1:0] rdw, old;
    bit conf;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_block = 2'(blk); cmd_page = 3'(pg); cmd_wdata = wd; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    check(busy && !cmd_ready, "R2", {busy, cmd_ready}, 2'b10);
    cycles = 0; nw = 0; rdw = '0;
    while (!done) begin
      if (rd_valid) begin
        if (nw < WPP) rdw[nw*WW +: WW] = rd_data;
        nw++;
      end
      if (spam && cycles == 1) begin
        cmd_op = 2'b10; cmd_block = 2'(blk); cmd_valid = 1;
      end
      if (spam && cycles == 2) cmd_valid = 0;
      cycles++;
      @(negedge clk);
    end
    check(cycles == exp_lat(op), "R7", cycles, exp_lat(op));
    check(!busy && cmd_ready, "R3", busy, 0);
    case (op)
      2'b00: begin
        check(nw == WPP, "R8", nw, WPP);
        check(rdw == model[blk*PPB+pg], rd_tag, rdw, model[blk*PPB+pg]);
        check(!prog_conflict, "R5", prog_conflict, 0);
      end
      2'b01: begin
        old = model[blk*PPB+pg];
        conf = |(wd & ~old);
        model[blk*PPB+pg] = old & wd;
        check(prog_conflict == conf, "R5", prog_conflict, conf);
      end
      2'b10: begin
        for (int p = 0; p < PPB; p++) model[blk*PPB+p] = '1;
        wear_m[blk]++;
        check(worn == exp_worn(), "R9", worn, exp_worn());
      end
      default: check(nw == 0 && !prog_conflict, "R10", nw, 0);
    endcase
    @(negedge clk);
    check(!done, "R3", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_F1A5));
    for (int i = 0; i < NB*PPB; i++) model[i] = '1;
    for (int b = 0; b < NB; b++) wear_m[b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && cmd_ready && !done && !rd_valid && !prog_conflict && worn == 0,
          "R1", {busy, cmd_ready, done, rd_valid, prog_conflict, worn}, 9'h080);
    rd_tag = "R1";
    for (int b = 0; b < NB; b++) run(2'b00, b, b*2 + 1, '0, 0);
    rd_tag = "R8";

    run(2'b01, 0, 2, 32'hF0F0_3C5A, 0);
    run(2'b01, 0, 2, 32'hFF00_FFFF, 0);
    run(2'b00, 0, 2, '0, 0);
    check(model[2] == 32'hF000_3C5A, "R4", model[2], 32'hF000_3C5A);
    run(2'b00, 0, 3, '0, 0);
    check(model[3] == '1, "R11", model[3], 32'hFFFFFFFF);
    run(2'b01, 0, 2, 32'h0F00_0000, 0);
    run(2'b01, 0, 2, 32'h0000_0000, 0);
    run(2'b11, 0, 2, '0, 0);
    check(!prog_conflict, "R5", prog_conflict, 0);
    run(2'b00, 0, 2, '0, 0);
    run(2'b01, 0, 4, 32'h1234_5678, 0);
    run(2'b01, 1, 4, 32'h8765_4321, 0);
    run(2'b10, 1, 0, '0, 0);
    rd_tag = "R6";
    run(2'b00, 0, 4, '0, 0);
    run(2'b00, 1, 4, '0, 0);
    rd_tag = "R8";
    run(2'b01, 2, 5, 32'hA5A5_0000, 1);
    rd_tag = "R2";
    run(2'b00, 2, 5, '0, 0);
    check(worn == 0, "R2", worn, 0);
    rd_tag = "R8";
    run(2'b11, 2, 5, '0, 0);
    rd_tag = "R10";
    run(2'b00, 2, 5, '0, 0);
    rd_tag = "R8";

    for (int k = 0; k < WL + 1; k++) run(2'b10, 3, 0, '0, 0);
    check(worn[3] == 1'b1, "R9", worn, 4'b1000);
    run(2'b10, 3, 0, '0, 0);
    check(worn[3] == 1'b1, "R9", worn[3], 1);

    begin
      int cyc, nw;
      logic [PW-1:0] rdw;
      @(negedge clk);
      cmd_op = 2'b01; cmd_block = 2'd2; cmd_page = 3'd3; cmd_wdata = 32'h0F0F_00FF; cmd_valid = 1;
      @(negedge clk);
      cmd_op = 2'b00;
      model[2*PPB+3] = model[2*PPB+3] & 32'h0F0F_00FF;
      while (!done) @(negedge clk);
      check(cmd_ready, "R2", cmd_ready, 1);
      @(negedge clk);
      cmd_valid = 0;
      check(busy && !done, "R3", {busy, done}, 2'b10);
      cyc = 0; nw = 0; rdw = '0;
      while (!done && cyc < 1000) begin
        if (rd_valid) begin
          if (nw < WPP) rdw[nw*WW +: WW] = rd_data;
          nw++;
        end
        cyc++;
        @(negedge clk);
      end
      check(rdw == model[2*PPB+3] && nw == WPP, "R8", rdw, model[2*PPB+3]);
    end

    for (int n = 0; n < 150; n++) begin
      int r, blk, pg;
      logic [1:0] op;
      r = $urandom_range(0, 99);
      blk = $urandom_range(0, NB-1);
      pg = $urandom_range(0, PPB-1);
      op = (r < 35) ? 2'b00 : (r < 80) ? 2'b01 : (r < 90) ? 2'b10 : 2'b11;
      run(op, blk, pg, $urandom() | $urandom(), 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule